// File: doc/BRIEF.md
# Modem Handshake Line Controller

This block serves one serial channel. It takes the two active-low handshake inputs, clear-to-send and carrier-detect, and passes each through a clock-domain synchroniser. It then watches each synchronised line for changes in either direction. A change is held in a sticky flag until a clear command arrives, and any flag whose enable is set raises the interrupt request. When automatic enabling is selected, a low clear-to-send line permits the transmitter and a low carrier-detect line permits the receiver. When it is not selected, both lines are plain general-purpose inputs and both permits stay on.

The block also drives the two active-low outputs: request-to-send and terminal-ready. Terminal-ready is the inverse of its control bit. Request-to-send goes low as soon as its bit is set. When the bit is cleared, the pin is released according to the line mode. In synchronous mode it is released at once. In asynchronous mode with automatic enabling, it stays low until the transmitter reports empty. In bit-oriented mode with automatic release, it stays low until the closing flag has finished leaving the transmit pin. The reset input is expected to be asserted asynchronously and released synchronously upstream.

Top module: `modem_ctl`

## Requirements
- R1: While reset is asserted and after it is released, with no further stimulus, rts_n and dtr_n are 1, both change flags are 0 and irq is 0.
- R2: One clock after dtr_bit is sampled, dtr_n equals the inverse of dtr_bit.
- R3: One clock after rts_bit is sampled as 1, rts_n is 0 in every mode.
- R4: In synchronous mode (mode = 1), rts_n is 1 one clock after rts_bit is sampled as 0, whatever the other inputs are. Mode value 3 behaves the same way.
- R5: In asynchronous mode (mode = 0) with auto_en = 1, rts_n stays 0 after rts_bit clears until tx_empty is sampled as 1, and is 1 one clock later. With auto_en = 0, rts_n is 1 one clock after the bit clears.
- R6: In bit-oriented mode (mode = 2) with auto_rts_rel = 1, rts_n stays 0 after rts_bit clears until a flag_done pulse is sampled, and is 1 one clock later. With auto_rts_rel = 0, rts_n is 1 one clock after the bit clears.
- R7: With auto_en = 1, tx_enable is 1 exactly when the synchronised cts_n is 0. A pin change becomes visible after two clocks. With auto_en = 0, tx_enable is 1.
- R8: With auto_en = 1, rx_enable is 1 exactly when the synchronised dcd_n is 0, with the same two-clock latency as R7. With auto_en = 0, rx_enable is 1.
- R9: A change of cts_n or dcd_n in either direction sets cts_chg or dcd_chg three clocks after the pin change. The flag stays set until clr_status is sampled as 1. A new change in the same cycle as the clear keeps the flag set.
- R10: irq is 1 exactly when (cts_chg and cts_ie) or (dcd_chg and dcd_ie). A flag whose enable is 0 does not raise irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier-detect pin, active low, asynchronous |
| mode | input | 2 | Line mode: 0 async, 1 sync, 2 bit-oriented, 3 treated as sync |
| auto_en | input | 1 | Automatic enables and async hold of request-to-send |
| auto_rts_rel | input | 1 | Bit-oriented automatic release of request-to-send |
| rts_bit | input | 1 | Request-to-send control bit |
| dtr_bit | input | 1 | Terminal-ready control bit |
| tx_empty | input | 1 | Transmitter fully drained |
| flag_done | input | 1 | Strobe: last zero of the closing flag has left the pin |
| cts_ie | input | 1 | Interrupt enable for clear-to-send changes |
| dcd_ie | input | 1 | Interrupt enable for carrier-detect changes |
| clr_status | input | 1 | Clears both sticky change flags |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| tx_enable | output | 1 | Transmitter permit |
| rx_enable | output | 1 | Receiver permit |
| cts_level | output | 1 | Synchronised clear-to-send level |
| dcd_level | output | 1 | Synchronised carrier-detect level |
| cts_chg | output | 1 | Sticky clear-to-send change flag |
| dcd_chg | output | 1 | Sticky carrier-detect change flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench holds request-to-send low for several cycles with the transmitter busy, and again with the closing flag outstanding. A design that released the pin on the bit alone would show rts_n high too early in those windows. It also checks that synchronous mode releases the pin at once even with automatic enabling on, which catches a design that applied the async hold in every mode. Pin changes are sampled cycle by cycle through the synchroniser. An edge detector that worked in only one direction would leave the flag clear after a rising pin, and a missing synchroniser stage would show the level or flag a cycle early. Interrupt masking is checked with a flag set and its enable off, which catches an unmasked request.

// File: rtl/modem_ctl_pkg.sv
package modem_ctl_pkg;

  typedef enum logic [1:0] {
    MC_ASYNC = 2'd0,
    MC_SYNC  = 2'd1,
    MC_BITOR = 2'd2,
    MC_RSVD  = 2'd3
  } mc_mode_e;

  localparam int MC_NUM_IN = 2;
  localparam int MC_IDX_CTS = 0;
  localparam int MC_IDX_DCD = 1;

endpackage

// File: rtl/mc_sync_edge.sv
module mc_sync_edge #(
  parameter int   WIDTH   = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] chg_pulse
);

  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] shr_q;
    logic [STAGES-1:0] shr_d;
    logic              prev_q;
    logic              prev_d;

    always_comb begin
      shr_d  = {shr_q[STAGES-2:0], din[g]};
      prev_d = shr_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shr_q  <= {STAGES{RST_VAL}};
        prev_q <= RST_VAL;
      end else begin
        shr_q  <= shr_d;
        prev_q <= prev_d;
      end
    end

    assign level[g]     = shr_q[LAST];
    assign chg_pulse[g] = shr_q[LAST] ^ prev_q;
  end

endmodule

// File: rtl/mc_status.sv
module mc_status #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] chg_pulse,
  input  logic [NSRC-1:0] ie,
  input  logic            clr,
  output logic [NSRC-1:0] flags,
  output logic            irq
);

  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] flag_d;

  // A new edge wins over a clear in the same cycle so no event is lost.
  always_comb begin
    flag_d = chg_pulse | (flag_q & ~{NSRC{clr}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & ie);

endmodule

// File: rtl/mc_line_drv.sv
module mc_line_drv
  import modem_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  mc_mode_e mode,
  input  logic     auto_en,
  input  logic     auto_rts_rel,
  input  logic     rts_bit,
  input  logic     dtr_bit,
  input  logic     tx_empty,
  input  logic     flag_done,
  output logic     rts_n,
  output logic     dtr_n
);

  logic rts_q, rts_d;
  logic dtr_q, dtr_d;
  logic hold_en;
  logic release_evt;

  always_comb begin
    hold_en     = 1'b0;
    release_evt = 1'b1;
    unique case (mode)
      MC_ASYNC: begin
        hold_en     = auto_en;
        release_evt = tx_empty;
      end
      MC_BITOR: begin
        hold_en     = auto_rts_rel;
        release_evt = flag_done;
      end
      default: begin
        hold_en     = 1'b0;
        release_evt = 1'b1;
      end
    endcase
  end

  always_comb begin
    if (rts_bit) rts_d = 1'b1;
    else         rts_d = rts_q & hold_en & ~release_evt;
    dtr_d = dtr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_q <= 1'b0;
      dtr_q <= 1'b0;
    end else begin
      rts_q <= rts_d;
      dtr_q <= dtr_d;
    end
  end

  assign rts_n = ~rts_q;
  assign dtr_n = ~dtr_q;

endmodule

// File: rtl/modem_ctl.sv
module modem_ctl
  import modem_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n,
  input  logic       dcd_n,
  input  logic [1:0] mode,
  input  logic       auto_en,
  input  logic       auto_rts_rel,
  input  logic       rts_bit,
  input  logic       dtr_bit,
  input  logic       tx_empty,
  input  logic       flag_done,
  input  logic       cts_ie,
  input  logic       dcd_ie,
  input  logic       clr_status,
  output logic       rts_n,
  output logic       dtr_n,
  output logic       tx_enable,
  output logic       rx_enable,
  output logic       cts_level,
  output logic       dcd_level,
  output logic       cts_chg,
  output logic       dcd_chg,
  output logic       irq
);

  logic [MC_NUM_IN-1:0] pin_raw;
  logic [MC_NUM_IN-1:0] pin_lvl;
  logic [MC_NUM_IN-1:0] pin_chg;
  logic [MC_NUM_IN-1:0] src_ie;
  logic [MC_NUM_IN-1:0] src_flag;
  mc_mode_e             mode_e;

  assign pin_raw[MC_IDX_CTS] = cts_n;
  assign pin_raw[MC_IDX_DCD] = dcd_n;
  assign src_ie[MC_IDX_CTS]  = cts_ie;
  assign src_ie[MC_IDX_DCD]  = dcd_ie;
  assign mode_e              = mc_mode_e'(mode);

  mc_sync_edge #(
    .WIDTH   (MC_NUM_IN),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (pin_raw),
    .level     (pin_lvl),
    .chg_pulse (pin_chg)
  );

  mc_status #(
    .NSRC (MC_NUM_IN)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .chg_pulse (pin_chg),
    .ie        (src_ie),
    .clr       (clr_status),
    .flags     (src_flag),
    .irq       (irq)
  );

  mc_line_drv u_drv (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode_e),
    .auto_en      (auto_en),
    .auto_rts_rel (auto_rts_rel),
    .rts_bit      (rts_bit),
    .dtr_bit      (dtr_bit),
    .tx_empty     (tx_empty),
    .flag_done    (flag_done),
    .rts_n        (rts_n),
    .dtr_n        (dtr_n)
  );

  assign cts_level = pin_lvl[MC_IDX_CTS];
  assign dcd_level = pin_lvl[MC_IDX_DCD];
  assign cts_chg   = src_flag[MC_IDX_CTS];
  assign dcd_chg   = src_flag[MC_IDX_DCD];
  assign tx_enable = ~auto_en | ~pin_lvl[MC_IDX_CTS];
  assign rx_enable = ~auto_en | ~pin_lvl[MC_IDX_DCD];

endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       auto_en,
  input logic       auto_rts_rel,
  input logic       rts_bit,
  input logic       dtr_bit,
  input logic       tx_empty,
  input logic       flag_done,
  input logic       cts_ie,
  input logic       dcd_ie,
  input logic       clr_status,
  input logic       rts_n,
  input logic       dtr_n,
  input logic       cts_chg,
  input logic       dcd_chg,
  input logic       irq
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> (rts_n && dtr_n && !irq)); // R1
  AST_DTR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n || !past_ok) dtr_n == !$past(dtr_bit)); // R2
  AST_RTS_ASSERT: assert property (@(posedge clk) disable iff (!rst_n || !past_ok) $past(rts_bit) |-> !rts_n); // R3
  AST_SYNC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok) $past(mode == 2'd1 && !rts_bit) |-> rts_n); // R4
  AST_ASYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !past_ok) $past(mode == 2'd0 && auto_en && !rts_n && !tx_empty) |-> !rts_n); // R5
  AST_BITOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !past_ok) $past(mode == 2'd2 && auto_rts_rel && !rts_n && !flag_done) |-> !rts_n); // R6
  AST_CTS_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !past_ok) $past(cts_chg && !clr_status) |-> cts_chg); // R9
  AST_DCD_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !past_ok) $past(dcd_chg && !clr_status) |-> dcd_chg); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (!cts_ie && !dcd_ie) |-> !irq); // R10
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (cts_chg || dcd_chg)); // R10

endmodule

bind modem_ctl modem_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode),
  .auto_en      (auto_en),
  .auto_rts_rel (auto_rts_rel),
  .rts_bit      (rts_bit),
  .dtr_bit      (dtr_bit),
  .tx_empty     (tx_empty),
  .flag_done    (flag_done),
  .cts_ie       (cts_ie),
  .dcd_ie       (dcd_ie),
  .clr_status   (clr_status),
  .rts_n        (rts_n),
  .dtr_n        (dtr_n),
  .cts_chg      (cts_chg),
  .dcd_chg      (dcd_chg),
  .irq          (irq)
);

// File: tb/modem_ctl_bench.sv
module modem_ctl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cts_n, dcd_n;
  logic [1:0] mode;
  logic       auto_en, auto_rts_rel, rts_bit, dtr_bit;
  logic       tx_empty, flag_done, cts_ie, dcd_ie, clr_status;
  logic       rts_n, dtr_n, tx_enable, rx_enable;
  logic       cts_level, dcd_level, cts_chg, dcd_chg, irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_ctl u_modem_ctl (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dcd_n(dcd_n), .mode(mode),
    .auto_en(auto_en), .auto_rts_rel(auto_rts_rel), .rts_bit(rts_bit),
    .dtr_bit(dtr_bit), .tx_empty(tx_empty), .flag_done(flag_done),
    .cts_ie(cts_ie), .dcd_ie(dcd_ie), .clr_status(clr_status),
    .rts_n(rts_n), .dtr_n(dtr_n), .tx_enable(tx_enable), .rx_enable(rx_enable),
    .cts_level(cts_level), .dcd_level(dcd_level), .cts_chg(cts_chg),
    .dcd_chg(dcd_chg), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cts_n = 1'b1; dcd_n = 1'b1; mode = 2'd1;
    auto_en = 1'b0; auto_rts_rel = 1'b0; rts_bit = 1'b0; dtr_bit = 1'b0;
    tx_empty = 1'b0; flag_done = 1'b0; cts_ie = 1'b0; dcd_ie = 1'b0; clr_status = 1'b0;
    step(3);
    chk("R1", "rts_n in reset", rts_n, 1'b1);
    chk("R1", "dtr_n in reset", dtr_n, 1'b1);
    rst_n = 1'b1;
    step(3);
    chk("R1", "rts_n idle", rts_n, 1'b1);
    chk("R1", "dtr_n idle", dtr_n, 1'b1);
    chk("R1", "cts_chg idle", cts_chg, 1'b0);
    chk("R1", "dcd_chg idle", dcd_chg, 1'b0);
    chk("R1", "irq idle", irq, 1'b0);
  endtask

  task automatic t_dtr();
    dtr_bit = 1'b1; step(1);
    chk("R2", "dtr_n after set", dtr_n, 1'b0);
    dtr_bit = 1'b0; step(1);
    chk("R2", "dtr_n after clear", dtr_n, 1'b1);
  endtask

  task automatic t_rts_sync();
    mode = 2'd1; auto_en = 1'b1; tx_empty = 1'b0;
    rts_bit = 1'b1; step(1);
    chk("R3", "rts_n set sync", rts_n, 1'b0);
    rts_bit = 1'b0; step(1);
    chk("R4", "rts_n sync release", rts_n, 1'b1);
    auto_en = 1'b0;
  endtask

  task automatic t_rts_async();
    mode = 2'd0; auto_en = 1'b1; tx_empty = 1'b0;
    rts_bit = 1'b1; step(1);
    chk("R3", "rts_n set async", rts_n, 1'b0);
    rts_bit = 1'b0; step(4);
    chk("R5", "rts_n held while busy", rts_n, 1'b0);
    tx_empty = 1'b1; step(1);
    chk("R5", "rts_n after drain", rts_n, 1'b1);
    rts_bit = 1'b1; step(1);
    rts_bit = 1'b0; step(1);
    chk("R5", "rts_n already drained", rts_n, 1'b1);
    auto_en = 1'b0; tx_empty = 1'b0;
    rts_bit = 1'b1; step(1);
    rts_bit = 1'b0; step(1);
    chk("R5", "rts_n async no auto", rts_n, 1'b1);
  endtask

  task automatic t_rts_bitor();
    mode = 2'd2; auto_rts_rel = 1'b1; flag_done = 1'b0;
    rts_bit = 1'b1; step(1);
    chk("R3", "rts_n set bitor", rts_n, 1'b0);
    rts_bit = 1'b0; step(3);
    chk("R6", "rts_n held for flag", rts_n, 1'b0);
    flag_done = 1'b1; step(1);
    flag_done = 1'b0;
    chk("R6", "rts_n after flag", rts_n, 1'b1);
    auto_rts_rel = 1'b0;
    rts_bit = 1'b1; step(1);
    rts_bit = 1'b0; step(1);
    chk("R6", "rts_n bitor no release", rts_n, 1'b1);
  endtask

  task automatic t_enables();
    auto_en = 1'b0; step(1);
    chk("R7", "tx_enable gp mode", tx_enable, 1'b1);
    chk("R8", "rx_enable gp mode", rx_enable, 1'b1);
    auto_en = 1'b1; step(1);
    chk("R7", "tx_enable cts high", tx_enable, 1'b0);
    chk("R8", "rx_enable dcd high", rx_enable, 1'b0);
    cts_n = 1'b0; dcd_n = 1'b0; step(1);
    chk("R7", "tx_enable one stage", tx_enable, 1'b0);
    chk("R8", "rx_enable one stage", rx_enable, 1'b0);
    step(1);
    chk("R7", "tx_enable synced", tx_enable, 1'b1);
    chk("R8", "rx_enable synced", rx_enable, 1'b1);
    chk("R9", "cts_chg before edge stage", cts_chg, 1'b0);
    step(1);
    chk("R9", "cts_chg falling", cts_chg, 1'b1);
    chk("R9", "dcd_chg falling", dcd_chg, 1'b1);
    auto_en = 1'b0;
  endtask

  task automatic t_edges();
    clr_status = 1'b1; step(1);
    clr_status = 1'b0;
    chk("R9", "cts_chg cleared", cts_chg, 1'b0);
    chk("R9", "dcd_chg cleared", dcd_chg, 1'b0);
    cts_n = 1'b1; step(2);
    chk("R9", "cts_chg rising early", cts_chg, 1'b0);
    step(1);
    chk("R9", "cts_chg rising", cts_chg, 1'b1);
    step(3);
    chk("R9", "cts_chg sticky", cts_chg, 1'b1);
    chk("R10", "irq masked", irq, 1'b0);
    dcd_ie = 1'b1; step(1);
    chk("R10", "irq other source only", irq, 1'b0);
    cts_ie = 1'b1; step(1);
    chk("R10", "irq enabled", irq, 1'b1);
    clr_status = 1'b1; step(1);
    clr_status = 1'b0;
    chk("R10", "irq after clear", irq, 1'b0);
    dcd_n = 1'b1; step(3);
    chk("R9", "dcd_chg rising", dcd_chg, 1'b1);
    chk("R10", "irq from dcd", irq, 1'b1);
  endtask

  initial begin
    t_reset();
    t_dtr();
    t_rts_sync();
    t_rts_async();
    t_rts_bitor();
    t_enables();
    t_edges();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule